// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block computes and checks parity for a 32-bit multiplexed address/data bus with 4 command/byte-enable lines. The parity rule is even: the 32 address/data bits, the 4 command/byte-enable bits and the parity bit together always hold an even number of ones. On the bus, the parity bit for a phase appears one clock after that phase. The block therefore registers its outgoing parity and the enable for that parity one clock behind the values they cover. On the receive side, it keeps the sampled bus values for one clock and compares them with the parity bit that arrives in the next clock.

A mismatch in a data phase that this device receives is reported on an active-low data-error line. That line is driven for the clock of the error report and for one clock after it. A mismatch in an address phase is reported as a single-clock active-low system-error pulse. Each report is gated by the enable bits of the command register. A status pulse marks every detected mismatch, whatever the enables are. A second status pulse follows the system-error line, so that the configuration block can set its status bits.

The bus interface drives `ad_out`/`cbe_out` together with `ad_oe` whenever it owns the bus. It marks received phases with `rx_addr` or `rx_data` in the clock in which it samples them.

Top module: `pci_par_unit`

## Requirements
- R1: When `par_oe` is high, `par_out` equals the XOR of the `ad_out` and `cbe_out` values from the previous clock. The 37 bits then contain an even number of ones.
- R2: `par_oe` equals `ad_oe` delayed by exactly one clock.
- R3: A data phase with `rx_data`=1 and `cmd_perr_resp`=1, both sampled with the phase, whose parity (`par_in` in the next clock) mismatches, drives `perr_n` low in the second clock after the phase, for one clock.
- R4: After a data phase with `rx_data`=1 and `cmd_perr_resp`=1, `perr_oe` is high in the second and third clocks after that phase. With `cmd_perr_resp`=0, `perr_n` stays high and `perr_oe` stays low even when the parity mismatches.
- R5: An address phase (`rx_addr`=1) with mismatched parity drives `serr_n` low for one clock, in the second clock after the phase, only if `cmd_serr_en` and `cmd_perr_resp` were both 1 with the phase.
- R6: `det_perr` pulses high for one clock, in the second clock after any qualified phase (address or data) whose parity mismatches, regardless of the enables.
- R7: A qualified phase with correct parity produces no `perr_n`, `serr_n` or `det_perr` activity.
- R8: A parity mismatch in a clock where neither `rx_addr` nor `rx_data` is set is ignored: there is no error output and no status pulse.
- R9: During reset, `par_oe`, `perr_oe`, `det_perr` and `sig_serr` are 0, and `perr_n` and `serr_n` are 1.
- R10: `sig_serr` is high exactly in the clocks in which `serr_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ad_out | input | 32 | Address/data value being driven this clock |
| cbe_out | input | 4 | Command/byte-enable value being driven this clock |
| ad_oe | input | 1 | High while this device drives the address/data bus |
| ad_in | input | 32 | Address/data value sampled from the bus |
| cbe_in | input | 4 | Command/byte-enable value sampled from the bus |
| par_in | input | 1 | Parity sampled from the bus (covers the previous clock) |
| rx_addr | input | 1 | This clock is an address phase to be checked |
| rx_data | input | 1 | This clock is a data phase received by this device |
| cmd_perr_resp | input | 1 | Command register parity-error-response enable |
| cmd_serr_en | input | 1 | Command register system-error enable |
| par_out | output | 1 | Generated parity |
| par_oe | output | 1 | Output enable for `par_out` |
| perr_n | output | 1 | Active-low data parity error |
| perr_oe | output | 1 | Output enable for `perr_n` |
| serr_n | output | 1 | Active-low system-error pulse (open-drain use) |
| det_perr | output | 1 | Status pulse: any parity mismatch detected |
| sig_serr | output | 1 | Status pulse: system error signalled |

## Verification
The assertions assume that the command enables are valid in the same clock as the phase qualifier they accompany. They also assume that `par_in` always carries the parity for the clock before it. The stimulus keeps both rules: each phase sets its enables together with its qualifier, and the driver places the parity computed for one step on `par_in` in the following step. The intended errors come from a flag that inverts that computed parity. Address and data qualifiers never fire in the same clock, as on a real bus.

// File: rtl/pci_par_unit.sv
module pci_par_unit #(
  parameter int AD_W = 32,
  parameter int BE_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AD_W-1:0] ad_out,
  input  logic [BE_W-1:0] cbe_out,
  input  logic            ad_oe,
  input  logic [AD_W-1:0] ad_in,
  input  logic [BE_W-1:0] cbe_in,
  input  logic            par_in,
  input  logic            rx_addr,
  input  logic            rx_data,
  input  logic            cmd_perr_resp,
  input  logic            cmd_serr_en,
  output logic            par_out,
  output logic            par_oe,
  output logic            perr_n,
  output logic            perr_oe,
  output logic            serr_n,
  output logic            det_perr,
  output logic            sig_serr
);

  localparam int CW = AD_W + BE_W;

  logic [CW-1:0] rx_q;
  logic          addr_chk, data_chk;
  logic          addr_rpt, data_rpt;
  logic          perr_drv, perr_drv_d;
  logic          mism;

  assign mism     = ^{rx_q, par_in};
  assign perr_oe  = perr_drv | perr_drv_d;
  assign sig_serr = ~serr_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      par_out    <= 1'b0;
      par_oe     <= 1'b0;
      rx_q       <= '0;
      addr_chk   <= 1'b0;
      data_chk   <= 1'b0;
      addr_rpt   <= 1'b0;
      data_rpt   <= 1'b0;
      perr_drv   <= 1'b0;
      perr_drv_d <= 1'b0;
      perr_n     <= 1'b1;
      serr_n     <= 1'b1;
      det_perr   <= 1'b0;
    end else begin
      par_out    <= ^{ad_out, cbe_out};
      par_oe     <= ad_oe;
      rx_q       <= {ad_in, cbe_in};
      addr_chk   <= rx_addr;
      data_chk   <= rx_data;
      addr_rpt   <= rx_addr & cmd_perr_resp & cmd_serr_en;
      data_rpt   <= rx_data & cmd_perr_resp;
      perr_drv   <= data_rpt;
      perr_drv_d <= perr_drv;
      perr_n     <= ~(data_rpt & mism);
      serr_n     <= ~(addr_rpt & mism);
      det_perr   <= (addr_chk | data_chk) & mism;
    end
  end

  assert_par_even_R1: assert property (@(posedge clk) disable iff (!rst_n)
    par_oe |-> ((^{$past(ad_out), $past(cbe_out), par_out}) == 1'b0));

  assert_par_oe_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |=> par_oe);

  assert_par_oe_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ad_oe |=> !par_oe);

  assert_perr_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n |-> ($past(cmd_perr_resp, 2) && $past(rx_data, 2)));

  assert_perr_driven_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n |-> perr_oe);

  assert_serr_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !serr_n |-> ($past(cmd_serr_en, 2) && $past(cmd_perr_resp, 2) && $past(rx_addr, 2)));

  assert_serr_flagged_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !serr_n |-> det_perr);

  assert_perr_flagged_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n |-> det_perr);

endmodule

// File: tb/test_pci_par_unit.sv
module test_pci_par_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ad_out = '0, ad_in = '0;
  logic [3:0]  cbe_out = '0, cbe_in = '0;
  logic        ad_oe = 1'b0, par_in = 1'b0, rx_addr = 1'b0, rx_data = 1'b0;
  logic        cmd_perr_resp = 1'b0, cmd_serr_en = 1'b0;
  logic        par_out, par_oe, perr_n, perr_oe, serr_n, det_perr, sig_serr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic next_par = 1'b0;
  logic prev_dpr = 1'b0;

  typedef struct {
    int    due;
    logic  oe;
    logic  par;
    string tag;
  } par_item_t;

  typedef struct {
    int    due;
    logic  perr_n;
    logic  perr_oe;
    logic  serr_n;
    logic  det;
    logic  sig;
    string tag;
  } err_item_t;

  par_item_t pq[$];
  err_item_t eq[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pci_par_unit i_pci_par_unit (
    .clk(clk), .rst_n(rst_n),
    .ad_out(ad_out), .cbe_out(cbe_out), .ad_oe(ad_oe),
    .ad_in(ad_in), .cbe_in(cbe_in), .par_in(par_in),
    .rx_addr(rx_addr), .rx_data(rx_data),
    .cmd_perr_resp(cmd_perr_resp), .cmd_serr_en(cmd_serr_en),
    .par_out(par_out), .par_oe(par_oe), .perr_n(perr_n), .perr_oe(perr_oe),
    .serr_n(serr_n), .det_perr(det_perr), .sig_serr(sig_serr)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b cycle=%0d", req, what, act, exp, cyc);
    end
  endtask

  // driver: one bus clock per call, pushes expectations into the scoreboard
  task automatic step(input logic [31:0] ad, input logic [3:0] cbe, input logic oe,
                      input logic addr, input logic data, input logic bad,
                      input logic pr, input logic se, input string tag);
    par_item_t p;
    err_item_t e;
    @(posedge clk);
    #5;
    ad_out = ad; cbe_out = cbe; ad_oe = oe;
    ad_in = ad; cbe_in = cbe;
    rx_addr = addr; rx_data = data;
    cmd_perr_resp = pr; cmd_serr_en = se;
    par_in = next_par;
    next_par = (^{ad, cbe}) ^ bad;
    p.due = cyc + 1; p.oe = oe; p.par = ^{ad, cbe}; p.tag = tag;
    pq.push_back(p);
    e.due = cyc + 2;
    e.perr_n = ~(data & pr & bad);
    e.perr_oe = (data & pr) | prev_dpr;
    e.serr_n = ~(addr & pr & se & bad);
    e.det = (addr | data) & bad;
    e.sig = addr & pr & se & bad;
    e.tag = tag;
    eq.push_back(e);
    prev_dpr = data & pr;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step('0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "idle");
  endtask

  // monitor: compares at the falling edge, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      while (pq.size() > 0 && pq[0].due == cyc) begin
        par_item_t p;
        p = pq.pop_front();
        check("R2", {p.tag, " par_oe"}, par_oe, p.oe);
        if (p.oe) check("R1", {p.tag, " par_out"}, par_out, p.par);
      end
      while (eq.size() > 0 && eq[0].due == cyc) begin
        err_item_t e;
        e = eq.pop_front();
        check("R3", {e.tag, " perr_n"}, perr_n, e.perr_n);
        check("R4", {e.tag, " perr_oe"}, perr_oe, e.perr_oe);
        check("R5", {e.tag, " serr_n"}, serr_n, e.serr_n);
        check("R6", {e.tag, " det_perr"}, det_perr, e.det);
        check("R10", {e.tag, " sig_serr"}, sig_serr, e.sig);
      end
    end
  end

  task automatic run_all();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset values
    check("R9", "par_oe", par_oe, 1'b0);
    check("R9", "perr_n", perr_n, 1'b1);
    check("R9", "perr_oe", perr_oe, 1'b0);
    check("R9", "serr_n", serr_n, 1'b1);
    check("R9", "det_perr", det_perr, 1'b0);
    check("R9", "sig_serr", sig_serr, 1'b0);
    @(posedge clk);
    #5 rst_n = 1'b1;
    idle(2);
    // R1 R2: generated parity over several patterns
    step(32'h0000_0000, 4'h0, 1, 0, 0, 0, 0, 0, "R1_zero");
    step(32'hFFFF_FFFF, 4'hF, 1, 0, 0, 0, 0, 0, "R1_ones");
    step(32'hA5A5_5A5A, 4'h7, 1, 0, 0, 0, 0, 0, "R1_mix");
    step(32'h0000_0001, 4'h0, 1, 0, 0, 0, 0, 0, "R1_single");
    step(32'h8000_0000, 4'h8, 0, 0, 0, 0, 0, 0, "R2_off");
    idle(1);
    // R7: correct parity on qualified phases
    step(32'h1234_5678, 4'h6, 0, 1, 0, 0, 1, 1, "R7_addr_ok");
    step(32'hDEAD_BEEF, 4'h0, 0, 0, 1, 0, 1, 1, "R7_data_ok");
    idle(2);
    // R3 R4 R6: data error reported
    step(32'h0F0F_0F0F, 4'h3, 0, 0, 1, 1, 1, 0, "R3_data_err");
    idle(3);
    // R4: response disabled, only status
    step(32'h0F0F_0F0F, 4'h3, 0, 0, 1, 1, 0, 0, "R4_resp_off");
    idle(3);
    // R8: mismatch without qualifier
    step(32'h5555_AAAA, 4'h9, 0, 0, 0, 1, 1, 1, "R8_unqualified");
    idle(3);
    // R5 R10: address error gating
    step(32'h0000_0040, 4'hA, 0, 1, 0, 1, 1, 1, "R5_serr");
    idle(3);
    step(32'h0000_0040, 4'hA, 0, 1, 0, 1, 1, 0, "R5_serr_en_off");
    idle(3);
    step(32'h0000_0040, 4'hA, 0, 1, 0, 1, 0, 1, "R5_resp_off");
    idle(3);
    // R3 R4: back-to-back data errors
    step(32'h1111_1111, 4'h1, 0, 0, 1, 1, 1, 0, "R3_burst0");
    step(32'h2222_2222, 4'h2, 0, 0, 1, 0, 1, 0, "R3_burst1");
    step(32'h3333_3333, 4'h3, 0, 0, 1, 1, 1, 0, "R3_burst2");
    idle(3);
    // mixed traffic
    for (int k = 0; k < 60; k++) begin
      logic a, d;
      a = ($urandom % 4) == 0;
      d = !a && (($urandom % 2) == 0);
      step($urandom, 4'($urandom), 1'($urandom), a, d, ($urandom % 3) == 0,
           1'($urandom), 1'($urandom), "R6_mixed");
    end
    idle(4);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule